// File: doc/BRIEF.md
# Dual-Select Static RAM Array

A 256 x 4 static memory with independent write-data and read-data ports. Access is enabled only when both select inputs are in their active state: one select is active low and the other active high, so two devices can share an address decoder with no extra gates. An output-disable input forces the output off in every mode. This lets the block sit on a bus that carries both read and write data. Any selected write still stores its data.

The three-state output is split into a data bus and an active-high enable, which a pad wrapper can turn into a real tri-state driver. A write is stored on the rising clock edge while the write conditions hold. Reads are combinational from the address and the stored contents. While the output is enabled during a selected write, it shows the incoming write data. The contents are not cleared at reset. An asynchronous active-low reset, released through a two-stage synchronizer, only blocks writes until the release has settled.

Top module: `dsram_array`

## Requirements
- R1: The block is selected only while `sel_lo_n` is 0 and `sel_hi` is 1.
- R2: While not selected, `q_oe` is 0 and `q` is 0, whatever `rd_wr_n` and `q_off` are.
- R3: While selected with `rd_wr_n` = 1 and `q_off` = 0, `q_oe` is 1 and `q` equals the word stored at `addr`, in the same cycle as the address.
- R4: While selected with `rd_wr_n` = 0, the value on `d` is stored at `addr` on the rising edge of `clk`.
- R5: During a selected write with `q_off` = 0, `q_oe` is 1 and `q` equals `d`.
- R6: `q_off` = 1 forces `q_oe` to 0 and `q` to 0 in every mode, and a selected write made with `q_off` = 1 is still stored.
- R7: While not selected, no word of the array changes, whatever `rd_wr_n`, `d` and `addr` do.
- R8: No write is stored while `rst_n` is 0, nor on the first two rising edges of `clk` after `rst_n` rises. Words written before the reset keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are stored on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; blocks writes only |
| addr | input | 8 | Word address |
| d | input | 4 | Write data |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| q_off | input | 1 | Output disable, active high |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| q | output | 4 | Read data or write pass-through; 0 while disabled |
| q_oe | output | 1 | Output enable for an external three-state driver |

## Verification
The bench writes every address and reads every address back, so an address decode that aliases words or drops a bit shows up as a wrong word on some read. Writes with the output disabled are mixed in: a design that lets the disable gate the write would read back stale data, and one that ignores the disable would raise `q_oe`. Each non-selecting combination of the two selects is swept with write attempts. A decoder that has a select polarity backwards, or that needs both selects to deselect, would then corrupt the array. Writes held across a reset and across its first two release edges must leave the old contents in place, which a missing or one-stage synchronizer would not.

// File: rtl/dsram_pkg.sv
package dsram_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } dsram_mode_e;
endpackage

// File: rtl/dsram_mode_dec.sv
module dsram_mode_dec
  import dsram_pkg::*;
(
  input  logic        sel_lo_n,
  input  logic        sel_hi,
  input  logic        rd_wr_n,
  output dsram_mode_e mode
);
  logic selected;

  always_comb begin
    selected = !sel_lo_n && sel_hi;
    if (!selected)    mode = MODE_IDLE;
    else if (rd_wr_n) mode = MODE_READ;
    else              mode = MODE_WRITE;
  end
endmodule

// File: rtl/dsram_rst_sync.sv
module dsram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/dsram_store.sv
module dsram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/dsram_out_stage.sv
module dsram_out_stage
  import dsram_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  dsram_mode_e       mode,
  input  logic              q_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] q,
  output logic              q_oe
);
  always_comb begin
    q_oe = (mode != MODE_IDLE) && !q_off;
    q    = '0;
    if (q_oe) begin
      if (mode == MODE_WRITE) q = wdata;
      else                    q = rdata;
    end
  end
endmodule

// File: rtl/dsram_array.sv
module dsram_array
  import dsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              q_off,
  input  logic              rd_wr_n,
  output logic [DATA_W-1:0] q,
  output logic              q_oe
);
  dsram_mode_e       mode;
  logic              rst_ok;
  logic              wr_en;
  logic [DATA_W-1:0] rdata;

  dsram_mode_dec dec_i (
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .rd_wr_n  (rd_wr_n),
    .mode     (mode)
  );

  dsram_rst_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  assign wr_en = (mode == MODE_WRITE) && rst_ok;

  dsram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (d),
    .rdata (rdata)
  );

  dsram_out_stage #(.DATA_W(DATA_W)) out_i (
    .mode  (mode),
    .q_off (q_off),
    .wdata (d),
    .rdata (rdata),
    .q     (q),
    .q_oe  (q_oe)
  );
endmodule

// File: rtl/dsram_chk.sv
module dsram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ok,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] d,
  input logic              sel_lo_n,
  input logic              sel_hi,
  input logic              q_off,
  input logic              rd_wr_n,
  input logic [DATA_W-1:0] q,
  input logic              q_oe
);
  p_unselected_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lo_n || !sel_hi) |-> !q_oe);

  p_off_means_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> (q == '0));

  p_select_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lo_n && sel_hi && !q_off) |-> q_oe);

  p_disable_forces_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_off |-> !q_oe);

  p_write_passthrough_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lo_n && sel_hi && !rd_wr_n && !q_off) |-> (q == d));

  p_write_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !sel_lo_n && sel_hi && !rd_wr_n) ##1
    (!sel_lo_n && sel_hi && rd_wr_n && !q_off && addr == $past(addr))
    |-> (q == $past(d)));
endmodule

bind dsram_array dsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_ok    (rst_ok),
  .addr     (addr),
  .d        (d),
  .sel_lo_n (sel_lo_n),
  .sel_hi   (sel_hi),
  .q_off    (q_off),
  .rd_wr_n  (rd_wr_n),
  .q        (q),
  .q_oe     (q_oe)
);

// File: tb/dsram_array_tb.sv
module dsram_array_tb_top;
  localparam int AW = 8;
  localparam int DW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] d;
  logic          sel_lo_n, sel_hi, q_off, rd_wr_n;
  logic [DW-1:0] q;
  logic          q_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] model [N];

  always #2 clk = ~clk;

  dsram_array dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .d(d),
    .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .q_off(q_off), .rd_wr_n(rd_wr_n),
    .q(q), .q_oe(q_oe)
  );

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a * 7 + 3 + k * 5) & ((1 << DW) - 1));
  endfunction

  task automatic check(string req, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got oe/q=%b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Drive at the falling edge, look 1 ns later.
  task automatic drive(logic s_n, logic s_h, logic off, logic rw, int a, logic [DW-1:0] v);
    @(negedge clk);
    sel_lo_n = s_n; sel_hi = s_h; q_off = off; rd_wr_n = rw;
    addr = AW'(a); d = v;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; sel_lo_n = 1; sel_hi = 0; q_off = 0; rd_wr_n = 1; addr = '0; d = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R2 reset idle", {q_oe, q}, '0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R4/R5/R6: fill the array; odd addresses written with the output disabled.
    for (int a = 0; a < N; a++) begin
      logic off;
      off = a[0];
      drive(0, 1, off, 0, a, pat(a, 0));
      model[a] = pat(a, 0);
      if (off) check("R6 write with disable", {q_oe, q}, '0);
      else     check("R5 write passthrough", {q_oe, q}, {1'b1, pat(a, 0)});
    end

    // R3/R4/R1: read back every word.
    for (int a = N - 1; a >= 0; a--) begin
      drive(0, 1, 0, 1, a, 4'h0);
      check("R3 R4 read back", {q_oe, q}, {1'b1, model[a]});
    end

    // R6: disabled read.
    drive(0, 1, 1, 1, 17, 4'h0);
    check("R6 disabled read", {q_oe, q}, '0);

    // R2/R7: every non-selecting select pair, write attempts with new data.
    for (int c = 0; c < 3; c++) begin
      logic sn, sh;
      sn = (c != 0);
      sh = (c == 1);
      for (int a = 0; a < N; a += 5) begin
        drive(sn, sh, a[1], 0, a, ~model[a]);
        check("R2 idle write attempt", {q_oe, q}, '0);
      end
      drive(sn, sh, 0, 1, 9, 4'h0);
      check("R2 idle read attempt", {q_oe, q}, '0);
    end
    for (int a = 0; a < N; a += 5) begin
      drive(0, 1, 0, 1, a, 4'h0);
      check("R7 idle left array alone", {q_oe, q}, {1'b1, model[a]});
    end

    // R8: write held through reset and its first two release edges.
    @(negedge clk);
    rst_n = 0;
    sel_lo_n = 0; sel_hi = 1; q_off = 0; rd_wr_n = 0; addr = 8'd11; d = ~model[11];
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rd_wr_n = 1;
    #1;
    check("R8 write blocked near reset", {q_oe, q}, {1'b1, model[11]});
    drive(0, 1, 0, 1, 10, 4'h0);
    check("R8 contents kept over reset", {q_oe, q}, {1'b1, model[10]});

    // R4: the third edge after release stores again.
    drive(0, 1, 0, 0, 11, pat(11, 3));
    model[11] = pat(11, 3);
    drive(0, 1, 0, 1, 11, 4'h0);
    check("R4 write after release", {q_oe, q}, {1'b1, model[11]});

    finish_run();
  end
endmodule